// File: doc/BRIEF.md
# Next-Address Unit with One Delay Slot

This block owns the fetch address of a 32-bit load/store core whose branches and jumps take effect one instruction late. Each cycle in which `issue` is high, the core presents the instruction word at `fetch_pc` together with its two source operand values. The unit decodes the control-transfer fields, evaluates the branch condition and advances `fetch_pc` at the clock edge. In the same cycle it raises a register-write request when a return address has to be saved, and a capture request for the exception return register when the instruction is a trap.

A taken branch or jump does not redirect the very next fetch. The instruction that sits after it, the delay-slot instruction, is always fetched and executed first, and the redirect follows the slot. A control-transfer instruction found inside a delay slot is executed for its side effects (its link write still happens) but it never redirects. A trap redirects at once to a fixed vector and cancels any redirect that is pending.

The sequencing is a three-state machine. `ST_RUN` is ordinary flow. From it, an issued branch or jump moves to `ST_SLOT_REDIR` when it is taken and to `ST_SLOT_FALL` when it is not. Both slot states return to `ST_RUN` on the next issued instruction: `ST_SLOT_REDIR` loads the saved target and `ST_SLOT_FALL` steps by 4. A trap in any state goes to `ST_RUN` at the vector. While `issue` is low the machine stays in its state.

Top module: `pcu_core`

## Requirements
- R1: While `rst_n` is low and after its release, before any issued instruction, `fetch_pc` equals RESET_PC (default 0), `slot_active` is 0, and with `issue` low `link_we` and `epc_we` are 0.
- R2: An issued instruction that is not a control transfer sets `fetch_pc` to `fetch_pc`+4 at the next edge. With `issue` low, `fetch_pc` and `slot_active` hold.
- R3: After an issued branch or jump in `ST_RUN`, `fetch_pc` becomes the old `fetch_pc`+4 and `slot_active` is 1. When the slot instruction issues, `fetch_pc` becomes the target if the branch was taken and slot address+4 if not, and `slot_active` returns to 0.
- R4: Opcode (bits 31:26) 000100 is taken when rs equals rt, 000101 when they differ, 000110 when rs is at most zero and 000111 when rs is above zero. The comparisons with zero are signed. The target is the branch address + 4 + (sign-extended bits 15:0) × 4.
- R5: With opcode 000001, the rt field (bits 20:16) selects the test: 00000 rs<0, 00001 rs>=0, 10000 rs<0 with link, 10001 rs>=0 with link. The target is formed as in R4. Any other rt value makes the instruction a non-control instruction.
- R6: Opcodes 000010 and 000011 always jump to {upper 4 bits of (address+4), bits 25:0, 2'b00}.
- R7: Opcode 000000 with function field (bits 5:0) 001000 or 001001 always jumps to the rs operand value.
- R8: Opcode 000011, and opcode 000001 with rt 10000 or 10001, raise `link_we` with `link_dst`=31. Function 001001 raises it with `link_dst`= bits 15:11. `link_val` is the instruction address+8. The request is made whether or not the condition holds, and also inside a delay slot.
- R9: A branch or jump issued inside a delay slot never redirects. The pending target (or the fall-through), not the slot branch's own target, follows it, and the instruction after that proceeds sequentially.
- R10: Opcode 000000 with function 001100 or 001101 raises `epc_we` with `epc_val` = its own address. `fetch_pc` becomes TRAP_VEC (default 0x3C) at the next edge, with `slot_active` 0. A pending redirect is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | The instruction at `fetch_pc` executes this cycle |
| instr | input | 32 | Instruction word at `fetch_pc` |
| rs_val | input | 32 | First source operand value |
| rt_val | input | 32 | Second source operand value |
| fetch_pc | output | 32 | Address of the instruction being presented |
| slot_active | output | 1 | The presented instruction is a delay-slot instruction |
| link_we | output | 1 | Return-address write request |
| link_dst | output | 5 | Register index for the return address |
| link_val | output | 32 | Return address |
| epc_we | output | 1 | Exception-return register capture request |
| epc_val | output | 32 | Value to capture |

## Verification
The link and trap requests are combinational on the presented instruction. They are due in the same cycle as `issue`, so the bench samples them 1 ns after driving, before the rising edge. `fetch_pc` and `slot_active` are due one edge after an issued instruction, and a taken redirect is due one edge after the slot instruction issues, which is two issued instructions after the branch. The bench drives on the falling edge and reads the next address on the following falling edge. It checks the slot address and the redirect address as separate steps, never collapsing the delay.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_SLOT_REDIR = 2'd1,
        ST_SLOT_FALL  = 2'd2
    } pcu_state_e;

    typedef enum logic [2:0] {
        CK_PLAIN = 3'd0,
        CK_COND  = 3'd1,
        CK_JABS  = 3'd2,
        CK_JREG  = 3'd3,
        CK_TRAP  = 3'd4
    } ctrl_kind_e;

    typedef enum logic [2:0] {
        CC_EQ  = 3'd0,
        CC_NE  = 3'd1,
        CC_LEZ = 3'd2,
        CC_GTZ = 3'd3,
        CC_LTZ = 3'd4,
        CC_GEZ = 3'd5,
        CC_ALW = 3'd6
    } cond_e;

    typedef struct packed {
        ctrl_kind_e kind;
        cond_e      cond;
        logic       link;
        logic       link_rd;
    } ctrl_dec_t;

    localparam logic [5:0] OPC_SPECIAL = 6'b000000;
    localparam logic [5:0] OPC_REGIMM  = 6'b000001;
    localparam logic [5:0] OPC_JUMP    = 6'b000010;
    localparam logic [5:0] OPC_JLINK   = 6'b000011;
    localparam logic [5:0] OPC_BEQ     = 6'b000100;
    localparam logic [5:0] OPC_BNE     = 6'b000101;
    localparam logic [5:0] OPC_BLEZ    = 6'b000110;
    localparam logic [5:0] OPC_BGTZ    = 6'b000111;

    localparam logic [5:0] FN_JREG     = 6'b001000;
    localparam logic [5:0] FN_JREGL    = 6'b001001;
    localparam logic [5:0] FN_SYSTRAP  = 6'b001100;
    localparam logic [5:0] FN_BRKTRAP  = 6'b001101;

    localparam logic [4:0] RT_LTZ      = 5'b00000;
    localparam logic [4:0] RT_GEZ      = 5'b00001;
    localparam logic [4:0] RT_LTZL     = 5'b10000;
    localparam logic [4:0] RT_GEZL     = 5'b10001;

    localparam logic [4:0] LINK_REG    = 5'd31;

endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
    import pcu_pkg::*;
(
    input  logic [5:0] opc,
    input  logic [4:0] rtf,
    input  logic [5:0] fn,
    output ctrl_dec_t  dec
);

    always_comb begin
        dec = '{kind: CK_PLAIN, cond: CC_ALW, link: 1'b0, link_rd: 1'b0};
        unique case (opc)
            OPC_SPECIAL: begin
                unique case (fn)
                    FN_JREG:    dec.kind = CK_JREG;
                    FN_JREGL: begin
                        dec.kind    = CK_JREG;
                        dec.link    = 1'b1;
                        dec.link_rd = 1'b1;
                    end
                    FN_SYSTRAP,
                    FN_BRKTRAP: dec.kind = CK_TRAP;
                    default:    dec.kind = CK_PLAIN;
                endcase
            end
            OPC_REGIMM: begin
                unique case (rtf)
                    RT_LTZ: begin
                        dec.kind = CK_COND;
                        dec.cond = CC_LTZ;
                    end
                    RT_GEZ: begin
                        dec.kind = CK_COND;
                        dec.cond = CC_GEZ;
                    end
                    RT_LTZL: begin
                        dec.kind = CK_COND;
                        dec.cond = CC_LTZ;
                        dec.link = 1'b1;
                    end
                    RT_GEZL: begin
                        dec.kind = CK_COND;
                        dec.cond = CC_GEZ;
                        dec.link = 1'b1;
                    end
                    default: dec.kind = CK_PLAIN;
                endcase
            end
            OPC_JUMP:  dec.kind = CK_JABS;
            OPC_JLINK: begin
                dec.kind = CK_JABS;
                dec.link = 1'b1;
            end
            OPC_BEQ: begin
                dec.kind = CK_COND;
                dec.cond = CC_EQ;
            end
            OPC_BNE: begin
                dec.kind = CK_COND;
                dec.cond = CC_NE;
            end
            OPC_BLEZ: begin
                dec.kind = CK_COND;
                dec.cond = CC_LEZ;
            end
            OPC_BGTZ: begin
                dec.kind = CK_COND;
                dec.cond = CC_GTZ;
            end
            default: dec.kind = CK_PLAIN;
        endcase
    end

endmodule

// File: rtl/pcu_cond.sv
module pcu_cond
    import pcu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cond_e            cond,
    input  logic [XLEN-1:0]  a_val,
    input  logic [XLEN-1:0]  b_val,
    output logic             hold
);

    logic neg;
    logic zero;
    logic same;

    always_comb begin
        neg  = a_val[XLEN-1];
        zero = (a_val == '0);
        same = (a_val == b_val);
    end

    always_comb begin
        unique case (cond)
            CC_EQ:   hold = same;
            CC_NE:   hold = !same;
            CC_LEZ:  hold = neg || zero;
            CC_GTZ:  hold = !neg && !zero;
            CC_LTZ:  hold = neg;
            CC_GEZ:  hold = !neg;
            default: hold = 1'b1;
        endcase
    end

endmodule

// File: rtl/pcu_target.sv
module pcu_target
    import pcu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  ctrl_kind_e       kind,
    input  logic [XLEN-1:0]  pc,
    input  logic [25:0]      field,
    input  logic [XLEN-1:0]  rs_val,
    output logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  ret_pc,
    output logic [XLEN-1:0]  target
);

    localparam int OFS_W = 16;
    localparam int EXT_W = XLEN - OFS_W - 2;
    localparam int HI_W  = XLEN - 28;

    logic [XLEN-1:0] rel_off;
    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] abs_tgt;

    always_comb begin
        seq_pc  = pc + XLEN'(4);
        ret_pc  = pc + XLEN'(8);
        rel_off = {{EXT_W{field[OFS_W-1]}}, field[OFS_W-1:0], 2'b00};
        rel_tgt = seq_pc + rel_off;
        abs_tgt = {seq_pc[XLEN-1 -: HI_W], field, 2'b00};
    end

    always_comb begin
        unique case (kind)
            CK_COND: target = rel_tgt;
            CK_JABS: target = abs_tgt;
            CK_JREG: target = rs_val;
            default: target = seq_pc;
        endcase
    end

endmodule

// File: rtl/pcu_core.sv
module pcu_core
    import pcu_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter logic [31:0] TRAP_VEC = 32'h0000_003C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [31:0]      instr,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    output logic [XLEN-1:0]  fetch_pc,
    output logic             slot_active,
    output logic             link_we,
    output logic [4:0]       link_dst,
    output logic [XLEN-1:0]  link_val,
    output logic             epc_we,
    output logic [XLEN-1:0]  epc_val
);

    localparam logic [XLEN-1:0] PC_INIT = XLEN'(RESET_PC);
    localparam logic [XLEN-1:0] PC_TRAP = XLEN'(TRAP_VEC);

    pcu_state_e      state_q, state_n;
    logic [XLEN-1:0] pc_q, pc_n;
    logic [XLEN-1:0] tgt_q, tgt_n;

    ctrl_dec_t       dec;
    logic            cond_hold;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] ret_pc;
    logic [XLEN-1:0] target;
    logic            is_ctrl;
    logic            is_trap;
    logic            taken;

    pcu_decode u_dec (
        .opc (instr[31:26]),
        .rtf (instr[20:16]),
        .fn  (instr[5:0]),
        .dec (dec)
    );

    pcu_cond #(.XLEN(XLEN)) u_cond (
        .cond  (dec.cond),
        .a_val (rs_val),
        .b_val (rt_val),
        .hold  (cond_hold)
    );

    pcu_target #(.XLEN(XLEN)) u_tgt (
        .kind   (dec.kind),
        .pc     (pc_q),
        .field  (instr[25:0]),
        .rs_val (rs_val),
        .seq_pc (seq_pc),
        .ret_pc (ret_pc),
        .target (target)
    );

    always_comb begin
        is_trap = (dec.kind == CK_TRAP);
        is_ctrl = (dec.kind == CK_COND) || (dec.kind == CK_JABS) ||
                  (dec.kind == CK_JREG);
        taken   = is_ctrl && ((dec.kind != CK_COND) || cond_hold);
    end

    // next-state and next-address logic
    always_comb begin
        state_n = state_q;
        pc_n    = pc_q;
        tgt_n   = tgt_q;
        if (issue) begin
            if (is_trap) begin
                state_n = ST_RUN;
                pc_n    = PC_TRAP;
            end else begin
                unique case (state_q)
                    ST_RUN: begin
                        pc_n = seq_pc;
                        if (is_ctrl) begin
                            state_n = taken ? ST_SLOT_REDIR : ST_SLOT_FALL;
                            tgt_n   = target;
                        end
                    end
                    ST_SLOT_REDIR: begin
                        state_n = ST_RUN;
                        pc_n    = tgt_q;
                    end
                    ST_SLOT_FALL: begin
                        state_n = ST_RUN;
                        pc_n    = seq_pc;
                    end
                    default: begin
                        state_n = ST_RUN;
                        pc_n    = seq_pc;
                    end
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pc_q    <= PC_INIT;
            tgt_q   <= PC_INIT;
        end else begin
            state_q <= state_n;
            pc_q    <= pc_n;
            tgt_q   <= tgt_n;
        end
    end

    // outputs
    always_comb begin
        fetch_pc    = pc_q;
        slot_active = (state_q != ST_RUN);
        link_we     = issue && dec.link;
        link_dst    = dec.link_rd ? instr[15:11] : LINK_REG;
        link_val    = ret_pc;
        epc_we      = issue && is_trap;
        epc_val     = pc_q;
    end

    // R2
    plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue && !slot_active && (dec.kind == CK_PLAIN)
        |=> fetch_pc == $past(fetch_pc) + XLEN'(4));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(fetch_pc) && $stable(slot_active));

    // R3
    slot_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue && !slot_active && is_ctrl
        |=> slot_active && fetch_pc == $past(fetch_pc) + XLEN'(4));

    // R3
    redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue && (state_q == ST_SLOT_REDIR) && !epc_we
        |=> fetch_pc == $past(tgt_q));

    // R9
    slot_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue && slot_active |=> !slot_active);

    // R10
    trap_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        epc_we |=> fetch_pc == PC_TRAP && !slot_active);

    // R8
    link_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (dec.kind == CK_COND) || (dec.kind == CK_JABS) ||
                    (dec.kind == CK_JREG));

endmodule

// File: tb/sim_pcu_core.sv
module sim_pcu_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] rs_val = 32'h0;
    logic [31:0] rt_val = 32'h0;
    logic [31:0] fetch_pc;
    logic        slot_active;
    logic        link_we;
    logic [4:0]  link_dst;
    logic [31:0] link_val;
    logic        epc_we;
    logic [31:0] epc_val;

    int n_chk  = 0;
    int n_fail = 0;

    logic        c_lwe, c_ewe, c_slot;
    logic [4:0]  c_dst;
    logic [31:0] c_lval, c_eval;

    always #4 clk = ~clk;

    pcu_core u0 (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .fetch_pc(fetch_pc),
        .slot_active(slot_active), .link_we(link_we), .link_dst(link_dst),
        .link_val(link_val), .epc_we(epc_we), .epc_val(epc_val)
    );

    localparam logic [31:0] BASE = 32'h1000_0100;
    localparam logic [31:0] NOP  = 32'h0000_0000;

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] rs;
        logic [31:0] rt;
        logic        lwe;
        logic [4:0]  dst;
        logic [31:0] nxt;
    } vec_t;

    localparam vec_t VT [16] = '{
        '{32'h1022_0010, 32'd5,          32'd5, 1'b0, 5'd0,  32'h1000_0144}, // R4 eq taken
        '{32'h1022_0010, 32'd5,          32'd6, 1'b0, 5'd0,  32'h1000_0108}, // R4 eq not
        '{32'h1422_0010, 32'd5,          32'd6, 1'b0, 5'd0,  32'h1000_0144}, // R4 ne taken
        '{32'h1820_FFFC, 32'd0,          32'd0, 1'b0, 5'd0,  32'h1000_00F4}, // R4 lez, neg offset
        '{32'h1C20_FFFC, 32'd0,          32'd0, 1'b0, 5'd0,  32'h1000_0108}, // R4 gtz not
        '{32'h1C20_FFFC, 32'd1,          32'd0, 1'b0, 5'd0,  32'h1000_00F4}, // R4 gtz taken
        '{32'h0420_0010, 32'h8000_0000,  32'd0, 1'b0, 5'd0,  32'h1000_0144}, // R5 ltz
        '{32'h0421_0010, 32'd0,          32'd0, 1'b0, 5'd0,  32'h1000_0144}, // R5 gez
        '{32'h0430_0010, 32'd1,          32'd0, 1'b1, 5'd31, 32'h1000_0108}, // R5 R8 ltz link not taken
        '{32'h0431_0010, 32'd0,          32'd0, 1'b1, 5'd31, 32'h1000_0144}, // R5 R8 gez link
        '{32'h0800_0123, 32'd0,          32'd0, 1'b0, 5'd0,  32'h1000_048C}, // R6 jump
        '{32'h0C00_0123, 32'd0,          32'd0, 1'b1, 5'd31, 32'h1000_048C}, // R6 R8 jump link
        '{32'h0020_0008, 32'h2000_0000,  32'd0, 1'b0, 5'd0,  32'h2000_0000}, // R7 reg jump
        '{32'h0020_2809, 32'h3000_0010,  32'd0, 1'b1, 5'd5,  32'h3000_0010}, // R7 R8 reg jump link rd=5
        '{32'h0022_1021, 32'd7,          32'd7, 1'b0, 5'd0,  32'h1000_0108}, // R2 plain
        '{32'h0422_0010, 32'd0,          32'd0, 1'b0, 5'd0,  32'h1000_0108}  // R5 unknown rt is plain
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called just after a falling edge; returns just after the next one
    task automatic exec(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
        issue  = 1'b1;
        instr  = i;
        rs_val = a;
        rt_val = b;
        #1;
        c_lwe  = link_we;
        c_dst  = link_dst;
        c_lval = link_val;
        c_ewe  = epc_we;
        c_eval = epc_val;
        c_slot = slot_active;
        @(negedge clk);
        issue = 1'b0;
        #1;
    endtask

    task automatic set_pc(input logic [31:0] a);
        exec(32'h0020_0008, a, 32'd0);
        exec(NOP, 32'd0, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 fetch_pc in reset", fetch_pc, 32'h0);
        chk("R1 slot in reset", {31'd0, slot_active}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 fetch_pc after release", fetch_pc, 32'h0);
        chk("R1 link_we idle", {31'd0, link_we}, 32'd0);
        chk("R1 epc_we idle", {31'd0, epc_we}, 32'd0);

        // R2 hold and sequential step
        repeat (3) @(negedge clk);
        #1;
        chk("R2 hold while idle", fetch_pc, 32'h0);
        exec(NOP, 32'd0, 32'd0);
        chk("R2 step by 4", fetch_pc, 32'h4);

        // table of single control-transfer vectors
        for (int k = 0; k < 16; k++) begin
            set_pc(BASE);
            exec(VT[k].ins, VT[k].rs, VT[k].rt);
            chk($sformatf("R8 link_we vector %0d", k), {31'd0, c_lwe}, {31'd0, VT[k].lwe});
            if (VT[k].lwe) begin
                chk($sformatf("R8 link_dst vector %0d", k), {27'd0, c_dst}, {27'd0, VT[k].dst});
                chk($sformatf("R8 link_val vector %0d", k), c_lval, BASE + 32'd8);
            end
            chk($sformatf("R3 slot address vector %0d", k), fetch_pc, BASE + 32'd4);
            exec(NOP, 32'd0, 32'd0);
            chk($sformatf("R3 next address vector %0d", k), fetch_pc, VT[k].nxt);
        end

        // R9 branch in delay slot does not redirect
        set_pc(BASE);
        exec(32'h1022_0010, 32'd3, 32'd3);
        chk("R3 slot flag", {31'd0, slot_active}, 32'd1);
        exec(32'h1422_0020, 32'd1, 32'd2);
        chk("R9 slot flag seen", {31'd0, c_slot}, 32'd1);
        chk("R9 pending target wins", fetch_pc, 32'h1000_0144);
        chk("R9 slot cleared", {31'd0, slot_active}, 32'd0);
        exec(NOP, 32'd0, 32'd0);
        chk("R9 sequential after", fetch_pc, 32'h1000_0148);

        // R8 link inside a delay slot
        set_pc(BASE);
        exec(32'h0800_0123, 32'd0, 32'd0);
        exec(32'h0431_0010, 32'd0, 32'd0);
        chk("R8 link in slot we", {31'd0, c_lwe}, 32'd1);
        chk("R8 link in slot val", c_lval, 32'h1000_010C);
        chk("R9 jump target after slot", fetch_pc, 32'h1000_048C);
        exec(NOP, 32'd0, 32'd0);
        chk("R9 no second redirect", fetch_pc, 32'h1000_0490);

        // R10 traps
        set_pc(BASE);
        exec(32'h0000_000C, 32'd0, 32'd0);
        chk("R10 syscall epc_we", {31'd0, c_ewe}, 32'd1);
        chk("R10 syscall epc_val", c_eval, BASE);
        chk("R10 vector", fetch_pc, 32'h0000_003C);
        exec(32'h0000_000D, 32'd0, 32'd0);
        chk("R10 break epc_val", c_eval, 32'h0000_003C);
        chk("R10 break vector", fetch_pc, 32'h0000_003C);

        // R10 trap in slot cancels redirect
        set_pc(BASE);
        exec(32'h1022_0010, 32'd3, 32'd3);
        exec(32'h0000_000C, 32'd0, 32'd0);
        chk("R10 slot trap epc_val", c_eval, BASE + 32'd4);
        chk("R10 slot trap vector", fetch_pc, 32'h0000_003C);
        chk("R10 slot trap flag", {31'd0, slot_active}, 32'd0);
        exec(NOP, 32'd0, 32'd0);
        chk("R10 redirect cancelled", fetch_pc, 32'h0000_0040);

        // R6 upper bits kept from a high region
        set_pc(32'hF000_0000);
        exec(32'h0800_0123, 32'd0, 32'd0);
        exec(NOP, 32'd0, 32'd0);
        chk("R6 upper bits kept", fetch_pc, 32'hF000_048C);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule